// File: doc/BRIEF.md
# ADC Control and Status Register Block

This block is the bus-facing register set of an analog-to-digital converter. A simple 32-bit read/write port reaches six word-aligned registers: channel control, conversion status, result, configuration, general control and general status. Software starts a conversion by writing a channel number into the channel control register. The all-ones channel code (0x1F) stops the converter instead. When a conversion finishes, a completion flag is set and the result register is loaded. If the interrupt enable bit is set, a level interrupt is raised.

The converter behind the registers is modelled as a timed sequencer. The converter's digital output is read from an input port at the moment a conversion completes. The conversion time follows the configured clock divider and the averaging count. A continuous mode restarts conversions on the same channel until the stop code is written. A calibration request runs a fixed-length sequence that reports pass or fail, using a pass/fail input from the analog side. The calibration math itself and bus error signalling are not modelled.

Reads on the bus are combinational from the selected register. Writes take effect at the clock edge. Reading the result register clears the completion flag, and this also takes effect at that edge.

Top module: `adc_ctrl_regs`

## Requirements
- R1: After reset, every register reads as follows, and the interrupt output is low:
  - channel control reads 0x1F (stop code, interrupt disabled);
  - status, result, configuration, general control and general status read 0.
- R2: Register offsets, bit layout and invalid accesses:
  - Registers sit at offsets 0x00 (channel control), 0x08 (status), 0x0C (result), 0x14 (configuration), 0x18 (general control) and 0x1C (general status).
  - Configuration bits [16:0] are read/write.
  - Any other offset up to 0x30, any offset above 0x30 and any offset that is not a multiple of 4 reads 0, and a write there changes nothing.
- R3: Starting a conversion and its duration:
  - A write to channel control whose bits [4:0] are not 0x1F starts a conversion. Channel control bit 7 is the interrupt enable.
  - Status bit 0 becomes 1 exactly D cycles after the write edge, where D = CONV_CYCLES × 2^div × (2^(avg+2) if averaging is on, else 1).
  - div is configuration bits [6:5]. avg is configuration bits [15:14]. Averaging is general control bit 5.
  - General status bit 2 is 1 while a conversion is running.
- R4: The result register holds the converter input sampled at completion, masked by the resolution in configuration bits [3:2]:
  - 0 keeps 8 bits;
  - 1 keeps 10 bits;
  - 2 or 3 keeps all 12 bits.
- R5: Writing 0x1F into the channel field aborts a running conversion. No completion follows, and general status bit 2 reads 0.
- R6: Reading the result register clears status bit 0. Any write to channel control also clears it.
- R7: Overwrite control (configuration bit 16):
  - When the bit is 0 and status bit 0 is still 1, a new result is discarded.
  - When the bit is 1, the new result replaces the old one.
- R8: The interrupt output is high exactly while status bit 0 and the interrupt enable are both 1. It stays high until the flag is cleared.
- R9: With general control bit 6 set, a new conversion on the same channel starts right after each completion, so completions are spaced D cycles apart. This continues until 0x1F is written.
- R10: Calibration:
  - Writing 1 to general control bit 7 starts a calibration of CAL_CYCLES cycles. Bit 7 reads 1 while it runs and clears when it ends.
  - At the end, status bit 0 is set, which raises the interrupt if enabled even with the channel at 0x1F.
  - General status bit 1 is set to 1 if the pass input was low at the end, and to 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| sample_i | input | 12 | Converter digital output, taken at conversion completion |
| cal_pass_i | input | 1 | Calibration pass indication, taken at calibration end |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest state to reach is a completion that arrives while the flag from an earlier completion is still set. Any write to channel control clears the flag, so this can only happen in continuous mode with the result left unread. The stimulus therefore starts continuous conversions and waits for the first completion. It then changes the converter input right away and lets several further completions pass before reading. It does this once with overwrite off and once with overwrite on, to tell the kept value from the replaced one.

// File: rtl/adc_regs_pkg.sv
package adc_regs_pkg;
  localparam int OFS_CHAN = 'h00;
  localparam int OFS_STAT = 'h08;
  localparam int OFS_RSLT = 'h0C;
  localparam int OFS_CONF = 'h14;
  localparam int OFS_GCTL = 'h18;
  localparam int OFS_GSTS = 'h1C;
  localparam int OFS_LAST = 'h30;

  localparam int CH_W        = 5;
  localparam int CH_IE_BIT   = 7;
  localparam int CONF_W      = 17;
  localparam int CF_RES_LO   = 2;
  localparam int CF_DIV_LO   = 5;
  localparam int CF_AVG_LO   = 14;
  localparam int CF_OVW_BIT  = 16;
  localparam int GC_AVG_BIT  = 5;
  localparam int GC_CONT_BIT = 6;
  localparam int GC_CAL_BIT  = 7;
  localparam int GS_CALF_BIT = 1;
  localparam int GS_ACT_BIT  = 2;

  localparam int DIV_MAX_SHIFT = 3;
  localparam int AVG_MAX_SHIFT = 5;
  localparam int SHIFT_W       = 4;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_CONV, SEQ_CAL} seq_state_e;

  typedef enum logic [2:0] {
    RID_NONE, RID_CHAN, RID_STAT, RID_RSLT, RID_CONF, RID_GCTL, RID_GSTS
  } reg_id_e;

  typedef struct packed {
    logic wr_chan;
    logic wr_conf;
    logic wr_gctl;
    logic rd_rslt;
  } strobe_t;
endpackage

// File: rtl/adc_bus_decode.sv
module adc_bus_decode
  import adc_regs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output reg_id_e           rid,
  output strobe_t           strb
);
  logic in_range;

  assign in_range = (bus_addr[1:0] == 2'b00) && (int'(bus_addr) <= OFS_LAST);

  always_comb begin
    rid = RID_NONE;
    if (in_range) begin
      case (int'(bus_addr))
        OFS_CHAN: rid = RID_CHAN;
        OFS_STAT: rid = RID_STAT;
        OFS_RSLT: rid = RID_RSLT;
        OFS_CONF: rid = RID_CONF;
        OFS_GCTL: rid = RID_GCTL;
        OFS_GSTS: rid = RID_GSTS;
        default:  rid = RID_NONE;
      endcase
    end
  end

  always_comb begin
    strb.wr_chan = bus_sel && bus_wr && (rid == RID_CHAN);
    strb.wr_conf = bus_sel && bus_wr && (rid == RID_CONF);
    strb.wr_gctl = bus_sel && bus_wr && (rid == RID_GCTL);
    strb.rd_rslt = bus_sel && !bus_wr && (rid == RID_RSLT);
  end
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_regs_pkg::*;
#(
  parameter int CONV_CYCLES = 4,
  parameter int CAL_CYCLES  = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_conv,
  input  logic               stop_conv,
  input  logic               start_cal,
  input  logic               cont_en,
  input  logic [SHIFT_W-1:0] dur_shift,
  output logic               conv_active,
  output logic               cal_active,
  output logic               conv_done,
  output logic               cal_done
);
  localparam int CONV_MAX = CONV_CYCLES << (DIV_MAX_SHIFT + AVG_MAX_SHIFT);
  localparam int SPAN     = (CONV_MAX > CAL_CYCLES) ? CONV_MAX : CAL_CYCLES;
  localparam int CNT_W    = $clog2(SPAN + 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, dur_q, dur_d, dur_new;
  logic             cnt_en;

  assign dur_new = CNT_W'(CONV_CYCLES) << dur_shift;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    dur_d     = dur_q;
    conv_done = 1'b0;
    cal_done  = 1'b0;
    case (state_q)
      SEQ_CAL: begin
        if (cnt_q == '0) begin
          cal_done = 1'b1;
          state_d  = SEQ_IDLE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: begin
        if (start_cal) begin
          state_d = SEQ_CAL;
          cnt_d   = CNT_W'(CAL_CYCLES - 1);
        end else if (start_conv) begin
          state_d = SEQ_CONV;
          dur_d   = dur_new;
          cnt_d   = dur_new - 1'b1;
        end else if (stop_conv) begin
          state_d = SEQ_IDLE;
        end else if (state_q == SEQ_CONV) begin
          if (cnt_q == '0) begin
            conv_done = 1'b1;
            if (cont_en) cnt_d = dur_q - 1'b1;
            else         state_d = SEQ_IDLE;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
      end
    endcase
  end

  assign cnt_en = (state_q != SEQ_IDLE) || start_cal || start_conv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      dur_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
      if (start_conv) dur_q <= dur_d;
    end
  end

  assign conv_active = (state_q == SEQ_CONV);
  assign cal_active  = (state_q == SEQ_CAL);

  assert_stop_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_conv && !start_cal && state_q != SEQ_CAL) |=> (state_q == SEQ_IDLE));

  assert_cont_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && cont_en) |=> (state_q == SEQ_CONV));

  assert_cal_return_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |=> (state_q == SEQ_IDLE));
endmodule

// File: rtl/adc_result_stage.sv
module adc_result_stage #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_done,
  input  logic              cal_done,
  input  logic              clr,
  input  logic [DATA_W-1:0] sample,
  input  logic [1:0]        res_code,
  input  logic              ovw_en,
  output logic              done_q,
  output logic [DATA_W-1:0] result_q
);
  int                keep_w;
  logic [DATA_W-1:0] masked;
  logic              take, done_d, done_en;

  always_comb begin
    case (res_code)
      2'd0:    keep_w = DATA_W - 4;
      2'd1:    keep_w = DATA_W - 2;
      default: keep_w = DATA_W;
    endcase
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign masked[i] = sample[i] & (i < keep_w);
  end

  assign take    = conv_done && (ovw_en || !done_q);
  assign done_d  = conv_done || cal_done;
  assign done_en = conv_done || cal_done || clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q   <= 1'b0;
      result_q <= '0;
    end else begin
      if (done_en) done_q <= done_d;
      if (take) result_q <= masked;
    end
  end

  assert_keep_old_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !ovw_en && done_q) |=> $stable(result_q));

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !conv_done && !cal_done) |=> !done_q);

  assert_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> done_q);

  assert_res_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && res_code == 2'd0) |=> ((result_q >> (DATA_W - 4)) == '0));
endmodule

// File: rtl/adc_ctrl_regs.sv
module adc_ctrl_regs
  import adc_regs_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 12,
  parameter int CONV_CYCLES = 4,
  parameter int CAL_CYCLES  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              cal_pass_i,
  output logic              irq_o
);
  localparam logic [CH_W-1:0] CH_STOP = '1;

  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  reg_id_e rid;
  strobe_t strb;

  adc_bus_decode #(.ADDR_W(ADDR_W)) u_decode (
    .bus_sel (bus_sel),
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .rid     (rid),
    .strb    (strb)
  );

  logic [CH_W-1:0]   ch_sel_q, ch_sel_d;
  logic              ch_ie_q, ch_ie_d;
  logic [CONF_W-1:0] conf_q, conf_d;
  logic              avg_q, avg_d, cont_q, cont_d;
  logic              calf_q, calf_d;

  always_comb begin
    ch_sel_d = bus_wdata[CH_W-1:0];
    ch_ie_d  = bus_wdata[CH_IE_BIT];
    conf_d   = bus_wdata[CONF_W-1:0];
    avg_d    = bus_wdata[GC_AVG_BIT];
    cont_d   = bus_wdata[GC_CONT_BIT];
    calf_d   = !cal_pass_i;
  end

  logic unused_wdata_bits;
  assign unused_wdata_bits = ^{bus_wdata[31:CONF_W]};

  logic start_conv, stop_conv, start_cal, clr_done;
  logic conv_active, cal_active, conv_done, cal_done;
  logic [SHIFT_W-1:0] dur_shift;
  logic done_q;
  logic [DATA_W-1:0] result_q;

  assign start_conv = strb.wr_chan && (bus_wdata[CH_W-1:0] != CH_STOP);
  assign stop_conv  = strb.wr_chan && (bus_wdata[CH_W-1:0] == CH_STOP);
  assign start_cal  = strb.wr_gctl && bus_wdata[GC_CAL_BIT];
  assign clr_done   = strb.wr_chan || strb.rd_rslt;

  assign dur_shift = SHIFT_W'(conf_q[CF_DIV_LO +: 2])
                   + (avg_q ? SHIFT_W'(conf_q[CF_AVG_LO +: 2]) + SHIFT_W'(2) : '0);

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      ch_sel_q <= CH_STOP;
      ch_ie_q  <= 1'b0;
      conf_q   <= '0;
      avg_q    <= 1'b0;
      cont_q   <= 1'b0;
      calf_q   <= 1'b0;
    end else begin
      if (strb.wr_chan) begin
        ch_sel_q <= ch_sel_d;
        ch_ie_q  <= ch_ie_d;
      end
      if (strb.wr_conf) conf_q <= conf_d;
      if (strb.wr_gctl) begin
        avg_q  <= avg_d;
        cont_q <= cont_d;
      end
      if (cal_done) calf_q <= calf_d;
    end
  end

  adc_conv_seq #(
    .CONV_CYCLES(CONV_CYCLES),
    .CAL_CYCLES (CAL_CYCLES)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .start_conv (start_conv),
    .stop_conv  (stop_conv),
    .start_cal  (start_cal),
    .cont_en    (cont_q),
    .dur_shift  (dur_shift),
    .conv_active(conv_active),
    .cal_active (cal_active),
    .conv_done  (conv_done),
    .cal_done   (cal_done)
  );

  adc_result_stage #(.DATA_W(DATA_W)) u_result (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .conv_done(conv_done),
    .cal_done (cal_done),
    .clr      (clr_done),
    .sample   (sample_i),
    .res_code (conf_q[CF_RES_LO +: 2]),
    .ovw_en   (conf_q[CF_OVW_BIT]),
    .done_q   (done_q),
    .result_q (result_q)
  );

  always_comb begin
    bus_rdata = '0;
    case (rid)
      RID_CHAN: begin
        bus_rdata[CH_W-1:0]  = ch_sel_q;
        bus_rdata[CH_IE_BIT] = ch_ie_q;
      end
      RID_STAT: bus_rdata[0] = done_q;
      RID_RSLT: bus_rdata[DATA_W-1:0] = result_q;
      RID_CONF: bus_rdata[CONF_W-1:0] = conf_q;
      RID_GCTL: begin
        bus_rdata[GC_AVG_BIT]  = avg_q;
        bus_rdata[GC_CONT_BIT] = cont_q;
        bus_rdata[GC_CAL_BIT]  = cal_active;
      end
      RID_GSTS: begin
        bus_rdata[GS_CALF_BIT] = calf_q;
        bus_rdata[GS_ACT_BIT]  = conv_active;
      end
      default: bus_rdata = '0;
    endcase
  end

  assign irq_o = done_q && ch_ie_q;

  assert_bad_write_R2: assert property (@(posedge clk) disable iff (!rst_n_int)
    (bus_sel && bus_wr && (bus_addr[1:0] != 2'b00 || int'(bus_addr) > OFS_LAST))
    |=> ($stable(conf_q) && $stable(ch_sel_q) && $stable(ch_ie_q) && $stable(cont_q)));

  assert_cal_irq_R10: assert property (@(posedge clk) disable iff (!rst_n_int)
    (cal_done && ch_ie_q && !strb.wr_chan) |=> irq_o);
endmodule

// File: tb/adc_ctrl_regs_tb_top.sv
`timescale 1ns/1ps
module adc_ctrl_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [11:0] smp = '0;
  logic        cal_pass = 1'b1;
  logic        irq;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  adc_ctrl_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sample_i(smp), .cal_pass_i(cal_pass), .irq_o(irq)
  );

  localparam logic [7:0] A_CHAN = 8'h00, A_STAT = 8'h08, A_RSLT = 8'h0C;
  localparam logic [7:0] A_CONF = 8'h14, A_GCTL = 8'h18, A_GSTS = 8'h1C;

  typedef struct packed {
    logic [16:0] conf;
    logic        avg;
    logic [4:0]  ch;
    logic [11:0] smp;
    logic [11:0] res;
    logic [11:0] dur;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{17'h00008, 1'b0, 5'd3,  12'hABC, 12'hABC, 12'd4},
    '{17'h00020, 1'b0, 5'd0,  12'hABC, 12'h0BC, 12'd8},
    '{17'h00064, 1'b0, 5'd7,  12'hFFF, 12'h3FF, 12'd32},
    '{17'h00008, 1'b1, 5'd12, 12'h123, 12'h123, 12'd16},
    '{17'h0402C, 1'b1, 5'd30, 12'h5A5, 12'h5A5, 12'd64},
    '{17'h0C008, 1'b0, 5'd1,  12'h800, 12'h800, 12'd4},
    '{17'h0C008, 1'b1, 5'd15, 12'h001, 12'h001, 12'd128}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic wait_irq(input int limit, output int cnt);
    cnt = 0;
    while (!irq && cnt < limit) begin
      @(negedge clk);
      cnt++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog (all requirements) actual=expired expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset values
    bus_read(A_CHAN, rd); check("R1 chan reset", rd, 32'h1F);
    bus_read(A_STAT, rd); check("R1 stat reset", rd, 0);
    bus_read(A_RSLT, rd); check("R1 result reset", rd, 0);
    bus_read(A_CONF, rd); check("R1 conf reset", rd, 0);
    bus_read(A_GCTL, rd); check("R1 gctl reset", rd, 0);
    bus_read(A_GSTS, rd); check("R1 gsts reset", rd, 0);
    check("R1 irq reset", 32'(irq), 0);

    // R2 map and invalid offsets
    bus_write(A_CONF, 32'hFFFF_FFFF);
    bus_read(A_CONF, rd); check("R2 conf width", rd, 32'h1FFFF);
    bus_write(A_CONF, 32'h0);
    bus_write(8'h15, 32'h1FFFF);
    bus_read(A_CONF, rd); check("R2 unaligned write ignored", rd, 0);
    bus_write(8'h34, 32'h85);
    bus_write(8'h04, 32'h85);
    repeat (10) @(negedge clk);
    bus_read(A_CHAN, rd); check("R2 invalid chan writes ignored", rd, 32'h1F);
    bus_read(A_STAT, rd); check("R2 no conversion from invalid write", rd, 0);
    bus_read(8'h04, rd); check("R2 offset 0x04 reads 0", rd, 0);
    bus_read(8'h30, rd); check("R2 offset 0x30 reads 0", rd, 0);
    bus_read(8'h34, rd); check("R2 offset 0x34 reads 0", rd, 0);
    bus_read(8'h09, rd); check("R2 unaligned read 0", rd, 0);

    // R3 R4 R6 R8 vector table
    for (int k = 0; k < 7; k++) begin
      smp = VECS[k].smp;
      bus_write(A_CONF, 32'(VECS[k].conf));
      bus_write(A_GCTL, {26'd0, VECS[k].avg, 5'd0});
      bus_write(A_CHAN, {24'd0, 1'b1, 2'd0, VECS[k].ch});
      wait_irq(400, cnt);
      check($sformatf("R3 duration vec%0d", k), cnt, 32'(VECS[k].dur));
      bus_read(A_STAT, rd); check("R3 done flag set", rd, 1);
      check("R8 irq holds while flag set", 32'(irq), 1);
      bus_read(A_GSTS, rd); check("R3 active cleared after single", rd, 0);
      bus_read(A_RSLT, rd); check($sformatf("R4 result vec%0d", k), rd, 32'(VECS[k].res));
      bus_read(A_STAT, rd); check("R6 result read clears flag", rd, 0);
      check("R8 irq low after clear", 32'(irq), 0);
    end

    // R8 interrupt disabled, R6 channel write clears
    bus_write(A_CONF, 32'h8);
    bus_write(A_GCTL, 32'h0);
    bus_write(A_CHAN, 32'h02);
    repeat (10) @(negedge clk);
    check("R8 no irq when disabled", 32'(irq), 0);
    bus_read(A_STAT, rd); check("R8 flag set without enable", rd, 1);
    bus_write(A_CHAN, 32'h9F);
    bus_read(A_STAT, rd); check("R6 channel write clears flag", rd, 0);
    check("R6 irq low after channel write", 32'(irq), 0);

    // R5 stop aborts
    bus_write(A_CONF, 32'hC008);
    bus_write(A_GCTL, 32'h20);
    bus_write(A_CHAN, 32'h81);
    repeat (10) @(negedge clk);
    bus_read(A_GSTS, rd); check("R3 active while converting", rd, 32'h4);
    bus_write(A_CHAN, 32'h9F);
    repeat (200) @(negedge clk);
    check("R5 no irq after stop", 32'(irq), 0);
    bus_read(A_STAT, rd); check("R5 no completion after stop", rd, 0);
    bus_read(A_GSTS, rd); check("R5 active cleared", rd, 0);

    // R9 continuous, R7 overwrite on
    smp = 12'h111;
    bus_write(A_CONF, 32'h10008);
    bus_write(A_GCTL, 32'h40);
    bus_write(A_CHAN, 32'h85);
    wait_irq(100, cnt); check("R9 first completion", cnt, 4);
    bus_read(A_RSLT, rd); check("R9 first result", rd, 32'h111);
    smp = 12'h222;
    wait_irq(100, cnt); check("R9 restart spacing", cnt, 3);
    bus_read(A_RSLT, rd); check("R9 second result", rd, 32'h222);
    bus_read(A_GSTS, rd); check("R9 still active", rd, 32'h4);
    smp = 12'h333;
    wait_irq(100, cnt);
    smp = 12'h444;
    repeat (12) @(negedge clk);
    bus_read(A_STAT, rd); check("R7 flag stays set", rd, 1);
    bus_read(A_RSLT, rd); check("R7 overwrite on replaces", rd, 32'h444);
    bus_write(A_CHAN, 32'h9F);
    repeat (20) @(negedge clk);
    bus_read(A_STAT, rd); check("R9 stop ends continuous", rd, 0);
    bus_read(A_GSTS, rd); check("R9 inactive after stop", rd, 0);

    // R7 overwrite off
    smp = 12'h666;
    bus_write(A_CONF, 32'h00008);
    bus_write(A_CHAN, 32'h85);
    wait_irq(100, cnt); check("R7 first completion", cnt, 4);
    smp = 12'h777;
    repeat (12) @(negedge clk);
    bus_read(A_RSLT, rd); check("R7 overwrite off keeps old", rd, 32'h666);
    bus_write(A_CHAN, 32'h9F);
    bus_write(A_GCTL, 32'h0);

    // R10 calibration pass then fail
    cal_pass = 1'b1;
    bus_write(A_GCTL, 32'h80);
    bus_read(A_GCTL, rd); check("R10 busy bit", rd, 32'h80);
    wait_irq(100, cnt); check("R10 calibration length", cnt, 19);
    bus_read(A_GCTL, rd); check("R10 busy cleared", rd, 0);
    bus_read(A_GSTS, rd); check("R10 pass status", rd, 0);
    bus_read(A_STAT, rd); check("R10 flag set with stop code", rd, 1);
    bus_read(A_RSLT, rd);
    cal_pass = 1'b0;
    bus_write(A_GCTL, 32'h80);
    wait_irq(100, cnt); check("R10 second calibration length", cnt, 20);
    bus_read(A_GSTS, rd); check("R10 fail status", rd, 32'h2);
    check("R10 irq raised", 32'(irq), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule